// File: doc/BRIEF.md
# Protection Entry Configuration Register File

This block stores the settings of a physical memory protection unit. It holds one configuration byte and one address register for each of its entries, and one security control register. Software reads and writes them through a single-cycle register port. A configuration word packs several entry bytes, one per byte lane. Every write passes through the protection rules before anything is stored. These rules are per-entry locks, a guard from a locked neighbour that uses top-of-range matching, a bypass bit for rule locks, two sticky lockdown bits and a correction of a reserved permission encoding.

The stored registers go out flat to the region decoder and the access checker, which sit outside this block. A one-cycle pulse tells those consumers that some stored value has actually changed. A write that is filtered away, or that stores what was already there, gives no pulse. The register port is plain control: a write is taken on the clock edge where `csr_wr_en` is high. Read data depends combinationally on the space and index inputs. There is no back-pressure, because every access completes in one cycle.

Configuration byte layout, used throughout: bit 0 is R, bit 1 is W, bit 2 is X, bits 4:3 are the match mode (0 off, 1 top-of-range, 2 naturally aligned 4-byte, 3 naturally aligned power of two) and bit 7 is L (lock). Security register layout: bit 0 is lockdown (MML), bit 1 is whitelist policy (MMWP), bit 2 is rule-lock bypass (RLB). All other bits of that register read 0. Register spaces selected by `csr_space`: 0 configuration, 1 address, 2 security, 3 none (writes ignored, reads 0).

Top module: `pmp_cfg_regfile`

## Requirements
- R1: After reset every configuration byte, address register and security bit is 0, and `perm_changed` is low.
- R2: In configuration space, byte b (bits 8b+7:8b) of word n belongs to entry 4n+b, with XLEN/8 bytes per word. Entries at index 16 or above read as 0, and writes to them are dropped.
- R3: With MML clear, a configuration write to an entry is dropped when that entry has L set and RLB is clear. An address write is dropped under the same condition. When RLB is set, the entry can be written.
- R4: With MML clear, a configuration byte written with W=1 and R=0 is stored with both R and W cleared.
- R5: With MML set, a configuration write is kept when RLB is set, or when the new byte has L=1 and X=0, or when it has L=0 and bits 2:0 not equal to 3'b110. It is dropped otherwise, whether or not the entry is locked. The W=1 R=0 encoding is stored unchanged.
- R6: An address write to entry e is dropped when entry e+1 has L set and mode 1 (top-of-range). This holds whatever the value of RLB. The last entry has no such guard.
- R7: MML and MMWP, once set, cannot be cleared by any write.
- R8: A security write cannot raise RLB from 0 while any entry has L set. The other bits of that write are still applied.
- R9: `perm_changed` is high for exactly the one cycle after a write edge that changed stored state. It stays low otherwise, including for writes that leave every value unchanged.
- R10: `cfg_flat` carries entry e at bits 8e+7:8e and `addr_flat` carries entry e at bits XLEN*e+XLEN-1:XLEN*e. Reads in address space return that entry's register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr_en | input | 1 | Write strobe, taken at the rising edge |
| csr_space | input | 2 | Register space: 0 configuration, 1 address, 2 security, 3 none |
| csr_index | input | IDX_W | Word index within the selected space |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Read data for the selected space and index |
| cfg_flat | output | 8*NUM_ENTRIES | All configuration bytes, entry e at 8e |
| addr_flat | output | XLEN*NUM_ENTRIES | All address registers, entry e at XLEN*e |
| sec_mml | output | 1 | Lockdown bit |
| sec_mmwp | output | 1 | Whitelist policy bit |
| sec_rlb | output | 1 | Rule-lock bypass bit |
| perm_changed | output | 1 | One-cycle pulse after a state-changing write |

## Verification
A single configuration word write can hit several entries in the same cycle. In that one write, some bytes may be kept, some dropped by their locks and some rewritten by the W-only correction, and the change pulse has to be the OR over all of them. Random words with a sparse lock bit, aimed mostly at the in-range words, produce this mix often. Each case is judged byte by byte against a bench model, with the pulse expected only when at least one stored byte differs. A second overlap comes from a lock in one entry's configuration byte together with a write to the address register of the entry below it, and directed cases with RLB set separate that guard from the entry's own lock.

// File: rtl/pmp_cfg_pkg.sv
package pmp_cfg_pkg;
  localparam int BIT_R = 0;
  localparam int BIT_W = 1;
  localparam int BIT_X = 2;
  localparam int BIT_L = 7;
  localparam int MODE_LO = 3;
  localparam logic [1:0] MODE_TOR = 2'd1;
  localparam logic [2:0] PERM_WX = 3'b110;

  localparam int SEC_MML  = 0;
  localparam int SEC_MMWP = 1;
  localparam int SEC_RLB  = 2;

  typedef enum logic [1:0] {
    SPACE_CFG  = 2'd0,
    SPACE_ADDR = 2'd1,
    SPACE_SEC  = 2'd2,
    SPACE_NONE = 2'd3
  } csr_space_e;

  function automatic logic [1:0] match_mode(input logic [7:0] c);
    return c[MODE_LO +: 2];
  endfunction
endpackage

// File: rtl/pmp_cfg_filter.sv
module pmp_cfg_filter
  import pmp_cfg_pkg::*;
(
  input  logic [7:0] cur_cfg,
  input  logic [7:0] wr_byte,
  input  logic       wr_hit,
  input  logic       mml,
  input  logic       rlb,
  output logic [7:0] nxt_cfg,
  output logic       upd
);
  logic       locked;
  logic       accept;
  logic [7:0] fixed;

  always_comb begin
    locked = cur_cfg[BIT_L] & ~rlb;
    if (mml) begin
      accept = rlb
             | (wr_byte[BIT_L] & ~wr_byte[BIT_X])
             | (~wr_byte[BIT_L] & (wr_byte[2:0] != PERM_WX));
    end else begin
      accept = ~locked;
    end
    fixed = wr_byte;
    if (!mml && wr_byte[BIT_W] && !wr_byte[BIT_R]) begin
      fixed[BIT_W] = 1'b0;
      fixed[BIT_R] = 1'b0;
    end
    nxt_cfg = (wr_hit && accept) ? fixed : cur_cfg;
    upd     = (nxt_cfg != cur_cfg);
  end
endmodule

// File: rtl/pmp_addr_gate.sv
module pmp_addr_gate #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cur_addr,
  input  logic [XLEN-1:0] wr_data,
  input  logic            wr_hit,
  input  logic            self_locked,
  input  logic            guard_locked,
  output logic [XLEN-1:0] nxt_addr,
  output logic            upd
);
  logic allow;

  always_comb begin
    allow    = wr_hit & ~self_locked & ~guard_locked;
    nxt_addr = allow ? wr_data : cur_addr;
    upd      = (nxt_addr != cur_addr);
  end
endmodule

// File: rtl/pmp_sec_ctrl.sv
module pmp_sec_ctrl
  import pmp_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_hit,
  input  logic [2:0] wr_bits,
  input  logic       any_lock,
  output logic       mml,
  output logic       mmwp,
  output logic       rlb,
  output logic       upd
);
  logic mml_n, mmwp_n, rlb_n;

  always_comb begin
    mml_n  = mml;
    mmwp_n = mmwp;
    rlb_n  = rlb;
    if (wr_hit) begin
      mml_n  = mml  | wr_bits[SEC_MML];
      mmwp_n = mmwp | wr_bits[SEC_MMWP];
      rlb_n  = (!rlb && any_lock) ? 1'b0 : wr_bits[SEC_RLB];
    end
    upd = (mml_n != mml) | (mmwp_n != mmwp) | (rlb_n != rlb);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mml  <= 1'b0;
      mmwp <= 1'b0;
      rlb  <= 1'b0;
    end else begin
      mml  <= mml_n;
      mmwp <= mmwp_n;
      rlb  <= rlb_n;
    end
  end
endmodule

// File: rtl/pmp_cfg_regfile.sv
module pmp_cfg_regfile
  import pmp_cfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32,
  parameter int IDX_W       = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        csr_wr_en,
  input  logic [1:0]                  csr_space,
  input  logic [IDX_W-1:0]            csr_index,
  input  logic [XLEN-1:0]             csr_wdata,
  output logic [XLEN-1:0]             csr_rdata,
  output logic [8*NUM_ENTRIES-1:0]    cfg_flat,
  output logic [XLEN*NUM_ENTRIES-1:0] addr_flat,
  output logic                        sec_mml,
  output logic                        sec_mmwp,
  output logic                        sec_rlb,
  output logic                        perm_changed
);
  localparam int BYTES_PER_WORD = XLEN / 8;
  localparam int ENTRIES_PER_STEP = 4;

  logic [NUM_ENTRIES-1:0][7:0]      cfg_q, cfg_nxt;
  logic [NUM_ENTRIES-1:0][XLEN-1:0] addr_q, addr_nxt;
  logic [NUM_ENTRIES-1:0]           cfg_upd, addr_upd, lock_raw;
  logic                             sec_upd;
  logic                             any_lock;
  logic                             perm_q;

  always_comb begin
    for (int e = 0; e < NUM_ENTRIES; e++) lock_raw[e] = cfg_q[e][BIT_L];
    any_lock = |lock_raw;
  end

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    logic       ent_hit;
    logic [7:0] ent_byte;
    logic       ent_addr_hit;
    logic       ent_guard;

    always_comb begin
      ent_hit  = 1'b0;
      ent_byte = '0;
      if (csr_wr_en && (csr_space == SPACE_CFG)) begin
        for (int b = 0; b < BYTES_PER_WORD; b++) begin
          if (int'(csr_index) * ENTRIES_PER_STEP + b == e) begin
            ent_hit  = 1'b1;
            ent_byte = csr_wdata[8*b +: 8];
          end
        end
      end
    end

    assign ent_addr_hit = csr_wr_en && (csr_space == SPACE_ADDR) &&
                          (int'(csr_index) == e);

    if (e < NUM_ENTRIES - 1) begin : g_guard
      assign ent_guard = cfg_q[e+1][BIT_L] && (match_mode(cfg_q[e+1]) == MODE_TOR);
    end else begin : g_noguard
      assign ent_guard = 1'b0;
    end

    pmp_cfg_filter u_filt (
      .cur_cfg (cfg_q[e]),
      .wr_byte (ent_byte),
      .wr_hit  (ent_hit),
      .mml     (sec_mml),
      .rlb     (sec_rlb),
      .nxt_cfg (cfg_nxt[e]),
      .upd     (cfg_upd[e])
    );

    pmp_addr_gate #(.XLEN(XLEN)) u_gate (
      .cur_addr     (addr_q[e]),
      .wr_data      (csr_wdata),
      .wr_hit       (ent_addr_hit),
      .self_locked  (cfg_q[e][BIT_L] & ~sec_rlb),
      .guard_locked (ent_guard),
      .nxt_addr     (addr_nxt[e]),
      .upd          (addr_upd[e])
    );

    assign cfg_flat[8*e +: 8]        = cfg_q[e];
    assign addr_flat[XLEN*e +: XLEN] = addr_q[e];
  end

  pmp_sec_ctrl u_sec (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_hit   (csr_wr_en && (csr_space == SPACE_SEC)),
    .wr_bits  (csr_wdata[2:0]),
    .any_lock (any_lock),
    .mml      (sec_mml),
    .mmwp     (sec_mmwp),
    .rlb      (sec_rlb),
    .upd      (sec_upd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      addr_q <= '0;
      perm_q <= 1'b0;
    end else begin
      cfg_q  <= cfg_nxt;
      addr_q <= addr_nxt;
      perm_q <= (|cfg_upd) | (|addr_upd) | sec_upd;
    end
  end

  assign perm_changed = perm_q;

  always_comb begin
    csr_rdata = '0;
    case (csr_space)
      SPACE_CFG: begin
        for (int b = 0; b < BYTES_PER_WORD; b++) begin
          for (int e = 0; e < NUM_ENTRIES; e++) begin
            if (int'(csr_index) * ENTRIES_PER_STEP + b == e) csr_rdata[8*b +: 8] = cfg_q[e];
          end
        end
      end
      SPACE_ADDR: begin
        for (int e = 0; e < NUM_ENTRIES; e++) begin
          if (int'(csr_index) == e) csr_rdata = addr_q[e];
        end
      end
      SPACE_SEC: begin
        csr_rdata[SEC_MML]  = sec_mml;
        csr_rdata[SEC_MMWP] = sec_mmwp;
        csr_rdata[SEC_RLB]  = sec_rlb;
      end
      default: csr_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pmp_cfg_regfile_chk.sv
module pmp_cfg_regfile_chk #(
  parameter int NUM_ENTRIES = 16,
  parameter int XLEN        = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [8*NUM_ENTRIES-1:0]    cfg_flat,
  input logic [XLEN*NUM_ENTRIES-1:0] addr_flat,
  input logic                        sec_mml,
  input logic                        sec_mmwp,
  input logic                        sec_rlb,
  input logic                        perm_changed
);
  logic any_l;
  logic any_w_only;

  always_comb begin
    any_l      = 1'b0;
    any_w_only = 1'b0;
    for (int e = 0; e < NUM_ENTRIES; e++) begin
      any_l      = any_l | cfg_flat[8*e+7];
      any_w_only = any_w_only | (cfg_flat[8*e+1] & ~cfg_flat[8*e]);
    end
  end

  assert_mml_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mml |=> sec_mml);
  assert_mmwp_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sec_mmwp |=> sec_mmwp);
  assert_rlb_guard_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_rlb && any_l) |=> !sec_rlb);
  assert_no_w_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_mml |-> !any_w_only);
  assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((cfg_flat != $past(cfg_flat)) || (addr_flat != $past(addr_flat)) ||
     ({sec_mml, sec_mmwp, sec_rlb} != $past({sec_mml, sec_mmwp, sec_rlb})))
    |-> perm_changed);
  assert_pulse_only_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    perm_changed |->
    ((cfg_flat != $past(cfg_flat)) || (addr_flat != $past(addr_flat)) ||
     ({sec_mml, sec_mmwp, sec_rlb} != $past({sec_mml, sec_mmwp, sec_rlb}))));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_chk
    assert_lock_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_flat[8*e+7] && !sec_rlb && !sec_mml) |=>
      ($stable(cfg_flat[8*e +: 8]) && $stable(addr_flat[XLEN*e +: XLEN])));
    if (e < NUM_ENTRIES - 1) begin : g_tor
      assert_tor_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_flat[8*(e+1)+7] && (cfg_flat[8*(e+1)+3 +: 2] == 2'd1)) |=>
        $stable(addr_flat[XLEN*e +: XLEN]));
    end
  end
endmodule

bind pmp_cfg_regfile pmp_cfg_regfile_chk #(
  .NUM_ENTRIES(NUM_ENTRIES),
  .XLEN(XLEN)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_flat     (cfg_flat),
  .addr_flat    (addr_flat),
  .sec_mml      (sec_mml),
  .sec_mmwp     (sec_mmwp),
  .sec_rlb      (sec_rlb),
  .perm_changed (perm_changed)
);

// File: tb/sim_pmp_cfg_regfile.sv
`timescale 1ns/1ps
module sim_pmp_cfg_regfile;
  localparam int N = 16;
  localparam int XL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          csr_wr_en = 1'b0;
  logic [1:0]    csr_space = 2'd3;
  logic [3:0]    csr_index = '0;
  logic [XL-1:0] csr_wdata = '0;
  logic [XL-1:0] csr_rdata;
  logic [8*N-1:0]  cfg_flat;
  logic [XL*N-1:0] addr_flat;
  logic sec_mml, sec_mmwp, sec_rlb, perm_changed;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [7:0]    m_cfg [N];
  logic [XL-1:0] m_addr[N];
  bit m_mml, m_mmwp, m_rlb;

  always #4 clk = ~clk;

  pmp_cfg_regfile #(.NUM_ENTRIES(N), .XLEN(XL), .IDX_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_wr_en(csr_wr_en), .csr_space(csr_space),
    .csr_index(csr_index), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .cfg_flat(cfg_flat), .addr_flat(addr_flat), .sec_mml(sec_mml),
    .sec_mmwp(sec_mmwp), .sec_rlb(sec_rlb), .perm_changed(perm_changed));

  task automatic chk(input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [8*N-1:0] pack_cfg();
    logic [8*N-1:0] v;
    for (int e = 0; e < N; e++) v[8*e +: 8] = m_cfg[e];
    return v;
  endfunction

  function automatic logic [XL*N-1:0] pack_addr();
    logic [XL*N-1:0] v;
    for (int e = 0; e < N; e++) v[XL*e +: XL] = m_addr[e];
    return v;
  endfunction

  task automatic mdl_cfg(input int idx, input logic [XL-1:0] wd, output bit chg);
    chg = 0;
    for (int b = 0; b < XL/8; b++) begin
      int e;
      logic [7:0] v;
      bit acc;
      e = idx*4 + b;
      v = wd[8*b +: 8];
      if (e < N) begin
        if (m_mml) acc = m_rlb || (v[7] && !v[2]) || (!v[7] && v[2:0] != 3'b110);
        else       acc = !(m_cfg[e][7] && !m_rlb);
        if (!m_mml && v[1] && !v[0]) v[1:0] = 2'b00;
        if (acc && v != m_cfg[e]) begin m_cfg[e] = v; chg = 1; end
      end
    end
  endtask

  task automatic mdl_addr(input int idx, input logic [XL-1:0] wd, output bit chg);
    bit guard, lk;
    chg = 0;
    if (idx < N) begin
      guard = (idx < N-1) && m_cfg[idx+1][7] && (m_cfg[idx+1][4:3] == 2'd1);
      lk = m_cfg[idx][7] && !m_rlb;
      if (!guard && !lk && wd != m_addr[idx]) begin m_addr[idx] = wd; chg = 1; end
    end
  endtask

  task automatic mdl_sec(input logic [XL-1:0] wd, output bit chg);
    bit any_l, nm, np, nr;
    any_l = 0;
    for (int e = 0; e < N; e++) any_l |= m_cfg[e][7];
    nm = m_mml | wd[0];
    np = m_mmwp | wd[1];
    nr = (!m_rlb && any_l) ? 1'b0 : wd[2];
    chg = (nm != m_mml) || (np != m_mmwp) || (nr != m_rlb);
    m_mml = nm; m_mmwp = np; m_rlb = nr;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    csr_wr_en = 1'b0;
    for (int e = 0; e < N; e++) begin m_cfg[e] = '0; m_addr[e] = '0; end
    m_mml = 0; m_mmwp = 0; m_rlb = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_op(input int sp, input int idx, input logic [XL-1:0] wd, input string tag);
    bit chg;
    chg = 0;
    csr_space = sp[1:0];
    csr_index = idx[3:0];
    csr_wdata = wd;
    csr_wr_en = 1'b1;
    case (sp)
      0: mdl_cfg(idx, wd, chg);
      1: mdl_addr(idx, wd, chg);
      2: mdl_sec(wd, chg);
      default: chg = 0;
    endcase
    @(negedge clk);
    csr_wr_en = 1'b0;
    chk(tag, "cfg_flat", cfg_flat, pack_cfg());
    chk(tag, "addr_flat", addr_flat, pack_addr());
    chk(tag, "sec", {sec_rlb, sec_mmwp, sec_mml}, {m_rlb, m_mmwp, m_mml});
    chk("R9", "perm_changed", perm_changed, chg);
  endtask

  task automatic chk_rd(input int sp, input int idx, input logic [XL-1:0] exp, input string tag);
    csr_wr_en = 1'b0;
    csr_space = sp[1:0];
    csr_index = idx[3:0];
    #1;
    chk(tag, "csr_rdata", csr_rdata, exp);
  endtask

  task automatic readback();
    for (int i = 0; i < 16; i++) begin
      logic [XL-1:0] w;
      w = '0;
      for (int b = 0; b < 4; b++) if (i*4 + b < N) w[8*b +: 8] = m_cfg[i*4 + b];
      chk_rd(0, i, w, "R2");
      chk_rd(1, i, m_addr[i], "R10");
    end
    chk_rd(2, 0, {29'd0, m_rlb, m_mmwp, m_mml}, "R8");
    chk_rd(3, 0, '0, "R2");
  endtask

  task automatic rand_phase(input int count, input bit allow_mml);
    for (int k = 0; k < count; k++) begin
      int sp, idx;
      logic [XL-1:0] wd;
      sp = int'($urandom % 4);
      idx = ($urandom % 8 == 0) ? int'($urandom % 16) : int'($urandom % 4);
      wd = $urandom;
      if (sp == 0) begin
        for (int b = 0; b < 4; b++) if ($urandom % 4 != 0) wd[8*b+7] = 1'b0;
        do_op(sp, idx, wd, "R3");
      end else if (sp == 1) begin
        do_op(sp, int'($urandom % 16), wd, "R6");
      end else if (sp == 2) begin
        if (!allow_mml) wd[0] = 1'b0;
        do_op(sp, idx, wd, "R8");
      end else begin
        do_op(sp, idx, wd, "R2");
      end
      if (k % 16 == 0) begin
        @(negedge clk);
        chk("R9", "idle perm_changed", perm_changed, 1'b0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk("R1", "cfg_flat", cfg_flat, '0);
    chk("R1", "addr_flat", addr_flat, '0);
    chk("R1", "sec", {sec_rlb, sec_mmwp, sec_mml}, 3'b000);
    chk("R1", "perm_changed", perm_changed, 1'b0);
    chk_rd(1, 7, '0, "R1");

    // R2 packing and out-of-range entries
    do_op(0, 1, 32'h0F091B03, "R2");
    chk("R2", "entries 4..7", cfg_flat[63:32], 32'h0F091B03);
    chk_rd(0, 1, 32'h0F091B03, "R2");
    do_op(0, 5, 32'hFFFFFFFF, "R2");
    chk_rd(0, 5, '0, "R2");

    // R4 W-only correction; a corrected write that stores the old value gives no pulse
    do_op(0, 0, 32'h00000002, "R4");
    chk("R4", "entry0", cfg_flat[7:0], 8'h00);
    do_op(0, 0, 32'h00000006, "R4");
    chk("R4", "entry0", cfg_flat[7:0], 8'h04);

    // R3 locks and bypass
    do_op(2, 0, 32'h4, "R3");
    do_op(0, 0, 32'h00000081, "R3");
    do_op(0, 0, 32'h00000083, "R3");
    chk("R3", "rlb bypass cfg", cfg_flat[7:0], 8'h83);
    do_op(1, 0, 32'h00001234, "R3");
    do_op(2, 0, 32'h0, "R3");
    do_op(0, 0, 32'h00000007, "R3");
    chk("R3", "locked cfg", cfg_flat[7:0], 8'h83);
    do_op(1, 0, 32'h00005555, "R3");
    chk("R3", "locked addr", addr_flat[31:0], 32'h00001234);

    // R8 RLB cannot rise while a lock exists
    do_op(2, 0, 32'h4, "R8");
    chk("R8", "rlb", sec_rlb, 1'b0);

    // R6 top-of-range guard, independent of RLB
    do_reset();
    do_op(2, 0, 32'h4, "R6");
    do_op(0, 0, 32'h89000000, "R6");
    do_op(1, 2, 32'h00000ABC, "R6");
    chk("R6", "addr2 guarded", addr_flat[95:64], 32'h0);
    do_op(1, 3, 32'h00000DEF, "R6");
    chk("R10", "addr3", addr_flat[127:96], 32'h00000DEF);
    do_op(1, 15, 32'h00000077, "R6");
    chk("R6", "last entry", addr_flat[XL*15 +: XL], 32'h77);
    do_op(1, 3, 32'h00000DEF, "R9");
    @(negedge clk);
    chk("R9", "idle", perm_changed, 1'b0);

    rand_phase(3000, 1'b0);
    readback();

    // R7 sticky bits
    do_reset();
    do_op(2, 0, 32'h3, "R7");
    do_op(2, 0, 32'h0, "R7");
    chk("R7", "mml mmwp", {sec_mmwp, sec_mml}, 2'b11);

    // R5 acceptance under lockdown
    do_op(0, 0, 32'h00000086, "R5");
    chk("R5", "L+X rejected", cfg_flat[7:0], 8'h00);
    do_op(0, 0, 32'h00000006, "R5");
    chk("R5", "WX rejected", cfg_flat[7:0], 8'h00);
    do_op(0, 0, 32'h00000002, "R5");
    chk("R5", "W-only kept", cfg_flat[7:0], 8'h02);
    do_op(0, 0, 32'h00000081, "R5");
    do_op(0, 0, 32'h00000083, "R5");
    chk("R5", "locked L no X", cfg_flat[7:0], 8'h83);
    do_op(0, 0, 32'h00000005, "R5");
    chk("R5", "locked L clear", cfg_flat[7:0], 8'h05);
    do_op(0, 0, 32'h00000006, "R5");
    chk("R5", "still", cfg_flat[7:0], 8'h05);

    rand_phase(3000, 1'b1);
    readback();

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule